// File: doc/BRIEF.md
# Fast Link Pulse Acknowledge Detector

This block sits behind the analog pulse qualifier of a twisted-pair transceiver during link negotiation. It takes one strobe per qualified link pulse and groups the pulses into bursts. Within a burst it tells clock pulses from data pulses by their timing, and from them it rebuilds the 16-bit code word that the link partner is advertising.

An acknowledge indication is raised only when the partner sends the same code word, with its acknowledge bit set, in three consecutive bursts. Each of those bursts must also be spaced legally from the one before it. Pulses that come too early are treated as noise and dropped. A burst that starts too soon after the previous one, a gap that runs too long and a burst that stops partway all throw away the consistency count.

Once acknowledge is reached, the block stops link pulse transmission and runs an inhibit interval. During that interval the link-status input is ignored and treated as failing. When the interval ends, a good link is reported; a failing link sends the block back to negotiation. All durations are counted in units of a timebase tick input, so they can be scaled down for simulation.

Top module: `flp_ack_detect`

## Requirements
- R1: A burst has 17 clock pulses. A data pulse that arrives between DATA_MIN and DATA_MAX ticks after clock pulse k (k = 1..16) sets bit k-1 of the word; the first slot is bit 0. When the 17th clock pulse is accepted, `code_word_o` takes the word of that burst.
- R2: Any pulse that arrives fewer than DATA_MIN ticks after the last accepted pulse, whether clock or data, is ignored. It changes neither the word nor the pulse timing.
- R3: `ack_o` rises after three consecutive accepted bursts that carry identical words with bit 14 (the acknowledge bit) set. Words with bit 14 clear never raise it.
- R4: Bursts whose words alternate between two values never raise `ack_o`.
- R5: A burst whose first pulse comes fewer than GAP_MIN ticks after the previous burst's last clock pulse is rejected. It does not update `code_word_o`, and it resets the consistency count to zero.
- R6: If no new burst starts within GAP_MAX ticks of the last one, the consistency count resets to zero.
- R7: A burst that sees no pulse for SLOT_MAX ticks before its 17th clock pulse is dropped, and the consistency count resets to zero.
- R8: From the acknowledge until the end of the inhibit interval, `ack_o` and `flp_tx_stop_o` are 1 and `link_good_o` is 0, whatever the value of `link_ok_i`.
- R9: INHIBIT ticks after the acknowledge, `link_good_o` rises if `link_ok_i` is 1. Otherwise `ack_o` and `flp_tx_stop_o` drop and reception restarts from an empty count.
- R10: While the link is reported good, `link_ok_i` going to 0 clears `link_good_o`, `ack_o` and `flp_tx_stop_o` on the next edge.
- R11: After a synchronous reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| tick_i | input | 1 | Timebase tick that advances every timer |
| pulse_i | input | 1 | One-cycle strobe per received link pulse |
| link_ok_i | input | 1 | Link status reported by the selected technology |
| code_word_o | output | 16 | Word from the most recently accepted burst |
| ack_o | output | 1 | Consistent acknowledging word detected |
| flp_tx_stop_o | output | 1 | Stop link pulse transmission |
| link_good_o | output | 1 | Link reported good after the inhibit interval |

## Verification
Walking-one and walking-zero words are swept through the decoder. This shows that every data slot maps to its own bit and that changing words never build up an acknowledge. Repeated acknowledging words, with and without injected noise pulses, separate correct noise rejection from corruption of the word. Alternating words and words with a clear acknowledge bit show that both identity and the acknowledge bit are required. Bursts sent too close together, bursts separated by an over-long gap and a truncated burst each have to restart the count of three, while the same sequence without the fault would have acknowledged. The pass and fail outcomes of the inhibit interval are both exercised, along with a link loss after a good link.

// File: rtl/flp_ack_pkg.sv
package flp_ack_pkg;

    localparam int WORD_W  = 16;
    localparam int ACK_BIT = 14;

    typedef enum logic [1:0] {
        LC_RX    = 2'd0,
        LC_CHECK = 2'd1,
        LC_GOOD  = 2'd2
    } lchk_state_t;

    typedef struct packed {
        logic              done;
        logic              abort;
        logic [WORD_W-1:0] word;
    } rx_evt_t;

    function automatic logic wants_ack(input logic [WORD_W-1:0] w);
        return w[ACK_BIT];
    endfunction

endpackage

// File: rtl/flp_burst_rx.sv
module flp_burst_rx
    import flp_ack_pkg::*;
#(
    parameter int CNT_W    = 20,
    parameter int DATA_MIN = 20,
    parameter int DATA_MAX = 78,
    parameter int SLOT_MAX = 200
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    hold,
    input  logic    tick,
    input  logic    pulse,
    output logic    active,
    output logic    start,
    output rx_evt_t evt
);
    localparam int SLOT_W = $clog2(WORD_W);
    localparam logic [CNT_W-1:0]  DMIN_L = CNT_W'(DATA_MIN);
    localparam logic [CNT_W-1:0]  DMAX_L = CNT_W'(DATA_MAX);
    localparam logic [CNT_W-1:0]  SMAX_L = CNT_W'(SLOT_MAX - 1);
    localparam logic [SLOT_W-1:0] LAST_L = SLOT_W'(WORD_W - 1);

    logic [CNT_W-1:0]  ptmr;
    logic [SLOT_W-1:0] slot;
    logic              got_data;
    logic [WORD_W-1:0] acc;
    logic              early;
    logic              is_data;

    assign early   = ptmr < DMIN_L;
    assign is_data = !got_data && (ptmr <= DMAX_L);
    assign start   = pulse && !active && !hold;

    always_ff @(posedge clk) begin
        if (rst) begin
            active   <= 1'b0;
            ptmr     <= '0;
            slot     <= '0;
            got_data <= 1'b0;
            acc      <= '0;
            evt      <= '0;
        end else if (hold) begin
            active    <= 1'b0;
            evt.done  <= 1'b0;
            evt.abort <= 1'b0;
        end else begin
            evt.done  <= 1'b0;
            evt.abort <= 1'b0;
            if (!active) begin
                if (pulse) begin
                    active   <= 1'b1;
                    ptmr     <= '0;
                    slot     <= '0;
                    got_data <= 1'b0;
                    acc      <= '0;
                end
            end else if (pulse && !early) begin
                ptmr <= '0;
                if (is_data) begin
                    acc[slot] <= 1'b1;
                    got_data  <= 1'b1;
                end else if (slot == LAST_L) begin
                    active   <= 1'b0;
                    evt.done <= 1'b1;
                    evt.word <= acc;
                end else begin
                    slot     <= slot + 1'b1;
                    got_data <= 1'b0;
                end
            end else if (tick) begin
                if (ptmr == SMAX_L) begin
                    active    <= 1'b0;
                    evt.abort <= 1'b1;
                end else begin
                    ptmr <= ptmr + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/flp_ack_match.sv
module flp_ack_match
    import flp_ack_pkg::*;
#(
    parameter int CNT_W   = 20,
    parameter int GAP_MIN = 5000,
    parameter int GAP_MAX = 150000,
    parameter int MATCH_N = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              tick,
    input  logic              rx_active,
    input  logic              start,
    input  rx_evt_t           evt,
    output logic [WORD_W-1:0] code_word,
    output logic              ack_set
);
    localparam int RUN_W = $clog2(MATCH_N + 1);
    localparam logic [CNT_W-1:0] GMIN_L = CNT_W'(GAP_MIN);
    localparam logic [CNT_W-1:0] GMAX_L = CNT_W'(GAP_MAX - 1);
    localparam logic [RUN_W-1:0] RUN_L  = RUN_W'(MATCH_N);

    logic [CNT_W-1:0]  gtmr;
    logic              have_prev;
    logic              too_close;
    logic [WORD_W-1:0] prev_word;
    logic [RUN_W-1:0]  run;
    logic [RUN_W-1:0]  next_run;
    logic              accept;

    assign accept = evt.done && !too_close;

    always_comb begin
        next_run = '0;
        if (wants_ack(evt.word)) begin
            if (run != '0 && evt.word == prev_word)
                next_run = (run == RUN_L) ? run : run + 1'b1;
            else
                next_run = RUN_W'(1);
        end
    end

    assign ack_set = accept && (next_run == RUN_L);

    always_ff @(posedge clk) begin
        if (rst)
            code_word <= '0;
        else if (accept)
            code_word <= evt.word;
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            gtmr      <= '0;
            have_prev <= 1'b0;
            too_close <= 1'b0;
            prev_word <= '0;
            run       <= '0;
        end else begin
            if (start)
                too_close <= have_prev && (gtmr < GMIN_L);
            if (evt.done) begin
                gtmr      <= '0;
                have_prev <= 1'b1;
                if (accept) begin
                    prev_word <= evt.word;
                    run       <= next_run;
                end else begin
                    run <= '0;
                end
            end else if (evt.abort) begin
                gtmr      <= '0;
                have_prev <= 1'b0;
                run       <= '0;
            end else if (have_prev && !rx_active && tick) begin
                if (gtmr == GMAX_L) begin
                    gtmr      <= '0;
                    have_prev <= 1'b0;
                    run       <= '0;
                end else begin
                    gtmr <= gtmr + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/flp_link_check.sv
module flp_link_check
    import flp_ack_pkg::*;
#(
    parameter int CNT_W   = 20,
    parameter int INHIBIT = 750000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        tick,
    input  logic        ack_set,
    input  logic        link_ok,
    output lchk_state_t state,
    output logic        restart
);
    localparam logic [CNT_W-1:0] INH_L = CNT_W'(INHIBIT - 1);

    logic [CNT_W-1:0] itmr;
    logic             expire;

    assign expire  = (state == LC_CHECK) && tick && (itmr == INH_L);
    assign restart = (expire && !link_ok) || ((state == LC_GOOD) && !link_ok);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= LC_RX;
            itmr  <= '0;
        end else begin
            case (state)
                LC_RX: begin
                    itmr <= '0;
                    if (ack_set)
                        state <= LC_CHECK;
                end
                LC_CHECK: begin
                    if (expire)
                        state <= link_ok ? LC_GOOD : LC_RX;
                    else if (tick)
                        itmr <= itmr + 1'b1;
                end
                LC_GOOD: begin
                    if (!link_ok)
                        state <= LC_RX;
                end
                default: state <= LC_RX;
            endcase
        end
    end
endmodule

// File: rtl/flp_ack_detect.sv
module flp_ack_detect
    import flp_ack_pkg::*;
#(
    parameter int CNT_W    = 20,
    parameter int DATA_MIN = 20,
    parameter int DATA_MAX = 78,
    parameter int SLOT_MAX = 200,
    parameter int GAP_MIN  = 5000,
    parameter int GAP_MAX  = 150000,
    parameter int INHIBIT  = 750000,
    parameter int MATCH_N  = 3
) (
    input  logic        clk_i,
    input  logic        rst_i,
    input  logic        tick_i,
    input  logic        pulse_i,
    input  logic        link_ok_i,
    output logic [15:0] code_word_o,
    output logic        ack_o,
    output logic        flp_tx_stop_o,
    output logic        link_good_o
);
    rx_evt_t     rx_evt;
    logic        rx_active;
    logic        rx_start;
    logic        rx_done;
    logic        ack_set;
    logic        restart;
    logic        hold;
    lchk_state_t lstate;

    assign hold    = (lstate != LC_RX);
    assign rx_done = rx_evt.done;

    flp_burst_rx #(
        .CNT_W(CNT_W), .DATA_MIN(DATA_MIN),
        .DATA_MAX(DATA_MAX), .SLOT_MAX(SLOT_MAX)
    ) u_rx (
        .clk(clk_i), .rst(rst_i), .hold(hold), .tick(tick_i),
        .pulse(pulse_i), .active(rx_active), .start(rx_start), .evt(rx_evt)
    );

    flp_ack_match #(
        .CNT_W(CNT_W), .GAP_MIN(GAP_MIN),
        .GAP_MAX(GAP_MAX), .MATCH_N(MATCH_N)
    ) u_match (
        .clk(clk_i), .rst(rst_i), .clear(restart), .tick(tick_i),
        .rx_active(rx_active), .start(rx_start), .evt(rx_evt),
        .code_word(code_word_o), .ack_set(ack_set)
    );

    flp_link_check #(
        .CNT_W(CNT_W), .INHIBIT(INHIBIT)
    ) u_lchk (
        .clk(clk_i), .rst(rst_i), .tick(tick_i), .ack_set(ack_set),
        .link_ok(link_ok_i), .state(lstate), .restart(restart)
    );

    assign ack_o         = (lstate != LC_RX);
    assign flp_tx_stop_o = (lstate == LC_CHECK) || (lstate == LC_GOOD);
    assign link_good_o   = (lstate == LC_GOOD);
endmodule

// File: rtl/flp_ack_detect_chk.sv
module flp_ack_detect_chk (
    input logic        clk,
    input logic        rst,
    input logic        link_ok_i,
    input logic [15:0] code_word_o,
    input logic        ack_o,
    input logic        flp_tx_stop_o,
    input logic        link_good_o,
    input logic        rx_done
);
    // R1
    word_on_burst_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(code_word_o) |-> $past(rx_done));

    // R3
    ack_on_burst_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ack_o) |-> $past(rx_done));

    // R8
    good_needs_stop_chk: assert property (@(posedge clk) disable iff (rst)
        link_good_o |-> flp_tx_stop_o);

    // R8
    stop_enter_not_good_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(flp_tx_stop_o) |-> !link_good_o);

    // R9
    good_needs_link_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(link_good_o) |-> $past(link_ok_i));

    // R10
    link_loss_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (link_good_o && !link_ok_i) |=> !link_good_o);
endmodule

bind flp_ack_detect flp_ack_detect_chk u_chk (
    .clk(clk_i), .rst(rst_i), .link_ok_i(link_ok_i),
    .code_word_o(code_word_o), .ack_o(ack_o),
    .flp_tx_stop_o(flp_tx_stop_o), .link_good_o(link_good_o),
    .rx_done(rx_done)
);

// File: tb/test_flp_ack_detect.sv
module test_flp_ack_detect;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick;
    logic        pls = 1'b0;
    logic        link_ok = 1'b1;
    logic [15:0] code_word;
    logic        ack, tx_stop, link_good;
    int          nvec = 0;
    int          nbad = 0;

    localparam logic [15:0] WA = 16'h4A5C;
    localparam logic [15:0] WB = 16'h4002;
    localparam logic [15:0] WN = 16'h0A5C;

    assign tick = 1'b1;
    always #5 clk = ~clk;

    flp_ack_detect #(
        .CNT_W(8), .DATA_MIN(2), .DATA_MAX(4), .SLOT_MAX(12),
        .GAP_MIN(20), .GAP_MAX(80), .INHIBIT(40), .MATCH_N(3)
    ) i_flp_ack_detect (
        .clk_i(clk), .rst_i(rst), .tick_i(tick), .pulse_i(pls),
        .link_ok_i(link_ok), .code_word_o(code_word), .ack_o(ack),
        .flp_tx_stop_o(tx_stop), .link_good_o(link_good)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        idle(3);
        rst = 1'b0;
        idle(1);
    endtask

    // clock pulse every 8 cycles, data pulse 4 cycles after its clock,
    // optional noise 1 cycle after a clock or after a data pulse
    task automatic burst(input logic [15:0] w, input bit noise, input int slots);
        for (int c = 0; c < slots * 8; c++) begin
            int s;
            int p;
            logic [3:0] b;
            logic bit_v;
            s = c / 8;
            p = c % 8;
            b = 4'(s);
            bit_v = (s < 16) && w[b];
            pls = (p == 0) || (p == 4 && bit_v) ||
                  (noise && s < 16 && (p == 1 || (p == 5 && bit_v)));
            @(negedge clk);
        end
        pls = 1'b0;
    endtask

    task automatic full(input logic [15:0] w);
        burst(w, 1'b0, 17);
        idle(32);
    endtask

    initial begin
        do_reset();
        // R11
        chk("R11 word", 32'(code_word), 0);
        chk("R11 ack", 32'(ack), 0);
        chk("R11 stop", 32'(tx_stop), 0);
        chk("R11 good", 32'(link_good), 0);

        // R1 walking one and walking zero sweep
        for (int i = 0; i < 16; i++) begin
            logic [15:0] w;
            w = 16'(1) << i;
            burst(w, 1'b0, 17);
            chk("R1 walk1", 32'(code_word), 32'(w));
            idle(32);
        end
        for (int i = 0; i < 16; i++) begin
            logic [15:0] w;
            w = ~(16'(1) << i);
            burst(w, 1'b0, 17);
            chk("R1 walk0", 32'(code_word), 32'(w));
            idle(32);
        end
        chk("R3 changing words", 32'(ack), 0);

        // R2 noise after clock and data pulses
        do_reset();
        burst(WA, 1'b1, 17); chk("R2 word", 32'(code_word), 32'(WA)); idle(32);
        burst(WA, 1'b1, 17); chk("R3 two bursts", 32'(ack), 0); idle(32);
        burst(WA, 1'b1, 17);
        chk("R2 word noisy", 32'(code_word), 32'(WA));
        chk("R3 three bursts", 32'(ack), 1);

        // R3 acknowledge bit clear
        do_reset();
        full(WN); full(WN); full(WN); full(WN);
        chk("R3 no ack bit word", 32'(code_word), 32'(WN));
        chk("R3 no ack bit", 32'(ack), 0);

        // R4 alternating words
        do_reset();
        for (int i = 0; i < 3; i++) begin
            full(WA);
            full(WB);
        end
        chk("R4 alternating", 32'(ack), 0);
        full(WA); full(WA);
        burst(WA, 1'b0, 17);
        chk("R4 recover", 32'(ack), 1);

        // R5 too close
        do_reset();
        full(WA);
        burst(WA, 1'b0, 17);
        burst(WB, 1'b0, 17);
        chk("R5 rejected word", 32'(code_word), 32'(WA));
        idle(32);
        full(WA); full(WA);
        chk("R5 count reset", 32'(ack), 0);
        burst(WA, 1'b0, 17);
        chk("R5 after restart", 32'(ack), 1);

        // R6 over-long gap
        do_reset();
        full(WA);
        burst(WA, 1'b0, 17);
        idle(100);
        full(WA); full(WA);
        chk("R6 count reset", 32'(ack), 0);
        burst(WA, 1'b0, 17);
        chk("R6 after restart", 32'(ack), 1);

        // R7 truncated burst
        do_reset();
        full(WA); full(WA);
        burst(WA, 1'b0, 5);
        idle(30);
        idle(32);
        full(WA); full(WA);
        chk("R7 count reset", 32'(ack), 0);
        burst(WA, 1'b0, 17);
        chk("R7 after restart", 32'(ack), 1);

        // R8 / R9 / R10 good link path
        do_reset();
        link_ok = 1'b1;
        full(WA); full(WA);
        burst(WA, 1'b0, 17);
        chk("R8 ack", 32'(ack), 1);
        chk("R8 stop", 32'(tx_stop), 1);
        chk("R8 good held low", 32'(link_good), 0);
        idle(25);
        chk("R8 inhibit good low", 32'(link_good), 0);
        idle(15);
        chk("R9 good after inhibit", 32'(link_good), 1);
        chk("R9 stop kept", 32'(tx_stop), 1);
        link_ok = 1'b0;
        idle(2);
        chk("R10 good dropped", 32'(link_good), 0);
        chk("R10 ack dropped", 32'(ack), 0);
        chk("R10 stop dropped", 32'(tx_stop), 0);

        // R9 failing link at expiry
        do_reset();
        link_ok = 1'b0;
        full(WA); full(WA);
        burst(WA, 1'b0, 17);
        idle(25);
        chk("R8 stop during inhibit", 32'(tx_stop), 1);
        idle(15);
        chk("R9 fail ack", 32'(ack), 0);
        chk("R9 fail stop", 32'(tx_stop), 0);
        chk("R9 fail good", 32'(link_good), 0);
        idle(10);
        full(WA); full(WA);
        chk("R9 restart empty count", 32'(ack), 0);
        burst(WA, 1'b0, 17);
        chk("R9 restart ack", 32'(ack), 1);

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        nvec++;
        nbad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end
endmodule